// File: doc/BRIEF.md
# Acquisition Host Bus Bridge

This block connects an external processor's parallel, memory-style bus to the data acquisition logic. The bus has separate read and write strobes, a shared address and a 32-bit data path. The address space is split into regions. Each of the lower regions maps to one converter's sample memory. The next region holds a single configuration word.

When the host writes the configuration word, the bridge latches it and presents it to the acquisition controller, which broadcasts it to the converters. On the next cycle the bridge raises a one-cycle load strobe and a one-cycle restart pulse for the acquisition sequencer.

On a read, the bridge does the following:
- It decodes the region and enables exactly one sample memory.
- It passes the word offset to that memory.
- It zero-extends the returned sample and registers it onto the read data bus.

Each sample memory presents the addressed word combinationally. Read data appears, with a valid flag, one clock after the read strobe.

Top module: `acq_host_bridge`

## Requirements
- R1: While reset is held and after its release, rd_valid, rd_data, cfg_load, seq_rst and ram_sel are all zero, and cfg_word equals the CFG_INIT parameter.
- R2: A write strobe at the configuration address (region NUM_BANKS, word offset 0; 0x300 with default parameters) puts host_wdata on cfg_word from the next cycle on. cfg_word then holds that value until the next configuration write.
- R3: cfg_load is high for exactly the one cycle after each configuration write. Two writes in consecutive cycles give two consecutive high cycles.
- R4: seq_rst is high for exactly the one cycle after each configuration write, with the same timing as cfg_load.
- R5: A write to any other address leaves cfg_word unchanged, and neither cfg_load nor seq_rst rises.
- R6: In a cycle with host_rd high and region b below NUM_BANKS (region = host_addr[ADDR_W-1:WORD_AW]), ram_sel equals 1<<b and ram_addr equals the low WORD_AW address bits. In every other cycle ram_sel is zero.
- R7: The cycle after a bank read, rd_valid is high for one cycle and rd_data holds the selected bank's sample, zero-extended from SAMPLE_W to DATA_W bits.
- R8: A read of the configuration address returns cfg_word as it was in the cycle of the read strobe. If a configuration write happens in the same cycle, the read returns the old value.
- R9: A read of an unmapped address returns zero with rd_valid high. Unmapped addresses are any region above NUM_BANKS, and any non-zero offset in the configuration region.
- R10: In every cycle where rd_valid is low, rd_data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | ADDR_W | Host address (region and word offset) |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_wdata | input | DATA_W | Host write data |
| host_rd | input | 1 | Host read strobe, one cycle per read |
| rd_data | output | DATA_W | Registered read data |
| rd_valid | output | 1 | rd_data valid, one cycle after host_rd |
| cfg_word | output | DATA_W | Latched converter initialisation word |
| cfg_load | output | 1 | One-cycle strobe: new cfg_word available for broadcast |
| seq_rst | output | 1 | One-cycle restart pulse for the acquisition sequencer |
| ram_sel | output | NUM_BANKS | One-hot read enable, one bit per sample memory |
| ram_addr | output | WORD_AW | Word offset passed to the sample memories |
| ram_rdata | input | NUM_BANKS*SAMPLE_W | Concatenated combinational read data of all memories, bank 0 in the low bits |

## Verification
The bench reads the first and last word of every bank back to back, using samples with the top bit set. A bridge that sign-extends, selects the wrong bank slice or loses one of two adjacent results would show up here. Configuration writes are sent alone, in consecutive pairs, to bank addresses, and to non-zero offsets of the configuration region. A decoder that ignores the offset, or a pulse stretched or merged across writes, changes cfg_word or the strobe count. A read issued in the same cycle as a configuration write must return the old word; a design that forwards the write data would return the new one. Unmapped regions and idle cycles must read as zero, which catches a multiplexer that keeps stale data.

// File: rtl/acq_host_bridge.sv
module acq_host_bridge #(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int SAMPLE_W  = 24,
  parameter int NUM_BANKS = 3,
  parameter int WORD_AW   = 8,
  parameter logic [31:0] CFG_INIT = 32'h0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             host_addr,
  input  logic                          host_wr,
  input  logic [DATA_W-1:0]             host_wdata,
  input  logic                          host_rd,
  output logic [DATA_W-1:0]             rd_data,
  output logic                          rd_valid,
  output logic [DATA_W-1:0]             cfg_word,
  output logic                          cfg_load,
  output logic                          seq_rst,
  output logic [NUM_BANKS-1:0]          ram_sel,
  output logic [WORD_AW-1:0]            ram_addr,
  input  logic [NUM_BANKS*SAMPLE_W-1:0] ram_rdata
);
  localparam int REG_W = ADDR_W - WORD_AW;
  localparam logic [REG_W-1:0] CFG_REGION = REG_W'(NUM_BANKS);

  logic [REG_W-1:0]   region;
  logic [WORD_AW-1:0] offset;
  logic               cfg_hit;
  logic               unmapped;
  logic [DATA_W-1:0]  rd_next;
  logic [DATA_W-1:0]  bank_word [NUM_BANKS];

  assign region   = host_addr[ADDR_W-1:WORD_AW];
  assign offset   = host_addr[WORD_AW-1:0];
  assign cfg_hit  = (region == CFG_REGION) && (offset == '0);
  assign unmapped = (region > CFG_REGION) || ((region == CFG_REGION) && (offset != '0));
  assign ram_addr = offset;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign ram_sel[b]   = host_rd && (region == REG_W'(b));
    assign bank_word[b] = DATA_W'(ram_rdata[b*SAMPLE_W +: SAMPLE_W]);
  end

  always_comb begin
    rd_next = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (region == REG_W'(b)) rd_next = bank_word[b];
    if (cfg_hit) rd_next = cfg_word;
    if (!host_rd) rd_next = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
      cfg_word <= DATA_W'(CFG_INIT);
      cfg_load <= 1'b0;
      seq_rst  <= 1'b0;
    end else begin
      rd_data  <= rd_next;
      rd_valid <= host_rd;
      cfg_load <= host_wr && cfg_hit;
      seq_rst  <= host_wr && cfg_hit;
      if (host_wr && cfg_hit) cfg_word <= host_wdata;
    end
  end

  p_cfg_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && cfg_hit) |=> (cfg_word == $past(host_wdata)));
  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_wr && cfg_hit) |=> $stable(cfg_word));
  p_load_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && cfg_hit) |=> cfg_load);
  p_load_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_wr && cfg_hit) |=> !cfg_load);
  p_rst_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && cfg_hit) |=> seq_rst);
  p_rst_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_wr && cfg_hit) |=> !seq_rst);
  p_sel_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ram_sel));
  p_sel_needs_rd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_sel != '0) |-> host_rd);
  p_valid_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd |=> rd_valid);
  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && unmapped) |=> (rd_data == '0));
  p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (rd_data == '0));
endmodule

// File: tb/acq_host_bridge_bench.sv
module acq_host_bridge_bench;
  localparam logic [31:0] INIT = 32'hA5A5_0001;
  localparam logic [11:0] CFG_A = 12'h300;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [11:0] host_addr = '0;
  logic        host_wr = 0, host_rd = 0;
  logic [31:0] host_wdata = '0;
  logic [31:0] rd_data, cfg_word;
  logic        rd_valid, cfg_load, seq_rst;
  logic [2:0]  ram_sel;
  logic [7:0]  ram_addr;
  logic [71:0] ram_rdata;

  int tests = 0, fails = 0;
  logic [31:0] exp_q[$];
  string       req_q[$];
  logic [31:0] cfg_model = INIT;
  bit          done = 0;

  always #4 clk = ~clk;

  acq_host_bridge #(.CFG_INIT(INIT)) u_acq_host_bridge (
    .clk, .rst_n, .host_addr, .host_wr, .host_wdata, .host_rd,
    .rd_data, .rd_valid, .cfg_word, .cfg_load, .seq_rst,
    .ram_sel, .ram_addr, .ram_rdata);

  function automatic logic [23:0] pat(int b, logic [7:0] a);
    return {4'(b + 9), 12'(a * 37), a ^ 8'h5A};
  endfunction

  for (genvar b = 0; b < 3; b++) begin : g_mem
    assign ram_rdata[b*24 +: 24] = pat(b, ram_addr);
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_valid) begin
        if (exp_q.size() == 0) chk(0, "R7 unexpected rd_valid", rd_data, 0);
        else begin
          automatic logic [31:0] e = exp_q.pop_front();
          automatic string r = req_q.pop_front();
          chk(rd_data == e, r, rd_data, e);
        end
      end else
        chk(rd_data == 0, "R10 idle data", rd_data, 0);
    end
  end

  task automatic rd(logic [11:0] a, logic [31:0] e, string req);
    automatic int reg_n = a[11:8];
    automatic logic [2:0] es = (reg_n < 3) ? 3'(1 << reg_n) : 3'b0;
    @(negedge clk);
    host_addr = a; host_rd = 1; host_wr = 0;
    exp_q.push_back(e); req_q.push_back(req);
    #1;
    chk(ram_sel == es, "R6 ram_sel", 32'(ram_sel), 32'(es));
    if (reg_n < 3) chk(ram_addr == a[7:0], "R6 ram_addr", 32'(ram_addr), 32'(a[7:0]));
  endtask

  task automatic idle();
    @(negedge clk);
    host_rd = 0; host_wr = 0;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    automatic bit hit = (a == CFG_A);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1; host_rd = 0;
    if (hit) cfg_model = d;
    @(negedge clk);
    host_wr = 0;
    chk(cfg_load == hit, hit ? "R3 load pulse" : "R5 no load", 32'(cfg_load), 32'(hit));
    chk(seq_rst == hit, hit ? "R4 restart pulse" : "R5 no restart", 32'(seq_rst), 32'(hit));
    chk(cfg_word == cfg_model, hit ? "R2 word taken" : "R5 word kept", cfg_word, cfg_model);
    @(negedge clk);
    chk(!cfg_load && !seq_rst, "R3 R4 single cycle", {cfg_load, seq_rst}, 0);
    chk(cfg_word == cfg_model, "R2 word held", cfg_word, cfg_model);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(rd_valid == 0 && rd_data == 0, "R1 read outputs in reset", rd_data, 0);
    chk(cfg_load == 0 && seq_rst == 0 && ram_sel == 0, "R1 strobes in reset",
        {cfg_load, seq_rst, ram_sel}, 0);
    chk(cfg_word == INIT, "R1 cfg init", cfg_word, INIT);
    rst_n = 1;
    @(negedge clk);
    chk(cfg_word == INIT && !cfg_load && !seq_rst, "R1 after release", cfg_word, INIT);

    for (int b = 0; b < 3; b++) begin
      rd({4'(b), 8'h00}, {8'h0, pat(b, 8'h00)}, "R7 bank first word");
      rd({4'(b), 8'hFF}, {8'h0, pat(b, 8'hFF)}, "R7 bank last word");
    end
    rd(12'h105, {8'h0, pat(1, 8'h05)}, "R7 bank1 mid");
    idle();
    rd(CFG_A, INIT, "R8 cfg readback");
    rd(12'h400, 0, "R9 region above cfg");
    rd(12'hFAB, 0, "R9 top region");
    rd(12'h301, 0, "R9 cfg region offset");
    idle();
    idle();

    wr(CFG_A, 32'hDEAD_BEEF);
    wr(12'h105, 32'h1111_2222);
    wr(12'h303, 32'h3333_4444);
    wr(12'h500, 32'h5555_6666);

    @(negedge clk);
    host_addr = CFG_A; host_wdata = 32'h0000_0A01; host_wr = 1;
    @(negedge clk);
    host_wdata = 32'h0000_0B02;
    chk(cfg_load && seq_rst, "R3 R4 first of pair", {cfg_load, seq_rst}, 3);
    chk(cfg_word == 32'h0000_0A01, "R2 first of pair", cfg_word, 32'h0000_0A01);
    @(negedge clk);
    host_wr = 0;
    chk(cfg_load && seq_rst, "R3 R4 second of pair", {cfg_load, seq_rst}, 3);
    chk(cfg_word == 32'h0000_0B02, "R2 second of pair", cfg_word, 32'h0000_0B02);
    cfg_model = 32'h0000_0B02;
    @(negedge clk);
    chk(!cfg_load && !seq_rst, "R3 R4 pair ends", {cfg_load, seq_rst}, 0);

    rd(CFG_A, cfg_model, "R8 cfg after writes");
    @(negedge clk);
    host_addr = CFG_A; host_rd = 1; host_wr = 1; host_wdata = 32'h7777_8888;
    exp_q.push_back(cfg_model); req_q.push_back("R8 read during write");
    idle();
    cfg_model = 32'h7777_8888;
    chk(cfg_word == cfg_model, "R2 write with read", cfg_word, cfg_model);
    rd(CFG_A, cfg_model, "R8 new word");
    idle();
    idle();
    chk(exp_q.size() == 0, "R7 all reads answered", exp_q.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule